// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache

This block keeps a small, fully associative cache of finished address translations. Each entry maps a guest-virtual page straight to a host-physical frame, with no guest-physical step in between. Each entry also records the identifier of the virtual machine that owns it. A hit needs both the page number and the identifier to match. Because of that, entries from several machines stay valid at the same time, and switching the active machine needs no invalidation.

A lookup presents a page number and the current identifier. One cycle later the block registers its answer: either a hit with the frame, or a miss. A miss raises a walk request that carries the missing page and identifier. An external walker returns the finished translation through the fill port, and the fill becomes a new entry. Two commands remove entries: one clears every entry whose identifier matches a given value, and the other clears the whole cache. Each takes one cycle.

Top module: `vmtlb`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid`, `rsp_hit` and `walk_req` are low, and any lookup misses.
- R2: A lookup hits only when a valid entry matches both the page number and the identifier. An entry with the same page under another identifier does not hit.
- R3: The cycle after `lk_valid` is high, `rsp_valid` is high and exactly one of `rsp_hit` and `walk_req` is high. `rsp_pfn` carries the frame on a hit and zero on a miss. Without a lookup, `rsp_valid` is low the next cycle.
- R4: On a miss, `walk_vpn` and `walk_tag` in the response cycle equal the page and identifier of the lookup that missed.
- R5: A fill can be looked up from the next cycle on. Entries for the same page under different identifiers coexist, and each returns its own frame.
- R6: A fill whose identifier and page pair is already present rewrites that entry's frame and does not use a second entry.
- R7: A fill goes to the lowest-numbered invalid entry whenever an invalid entry exists, so no valid entry is evicted.
- R8: When every entry is valid, a fill replaces the entry that a rotating pointer selects, and the pointer then advances by one. The pointer is zero after reset and after a flush of everything. Entries are filled in index order from empty, so the first fill after a full load evicts the oldest entry, and the next fill evicts the one after it.
- R9: A flush by identifier clears, in one cycle, exactly the entries with that identifier. Entries of other identifiers keep hitting.
- R10: A flush of everything clears all entries in one cycle.
- R11: Changing the identifier presented with lookups does not invalidate anything. Earlier entries still hit when their identifier is presented again.
- R12: A fill in the same cycle as either flush command is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 36 | Guest-virtual page number to translate |
| lk_tag | input | 8 | Identifier of the active virtual machine |
| rsp_valid | output | 1 | Registered answer to the previous cycle's lookup |
| rsp_hit | output | 1 | Answer is a hit |
| rsp_pfn | output | 28 | Host-physical frame on a hit, zero otherwise |
| walk_req | output | 1 | Answer is a miss; a page walk is required |
| walk_vpn | output | 36 | Page number to walk |
| walk_tag | output | 8 | Identifier to walk under |
| fill_valid | input | 1 | Write a finished translation |
| fill_vpn | input | 36 | Page number of the fill |
| fill_tag | input | 8 | Identifier of the fill |
| fill_pfn | input | 28 | Frame of the fill |
| flush_tag_valid | input | 1 | Clear all entries of `flush_tag` |
| flush_tag | input | 8 | Identifier to clear |
| flush_all | input | 1 | Clear every entry |

## Verification
The bench loads the same page under two identifiers. A design that matched on the page alone would return the wrong frame or hit under a third identifier. It refills an existing pair and then fills the cache to capacity. A design that made a duplicate would lose one live entry, and a later lookup would miss. After a flush by identifier frees half of a full cache, it fills new entries. A design that rotated without preferring free slots would evict entries of the surviving machine. It also checks which entry goes first under full-cache rotation, and that a fill colliding with a flush is discarded.

// File: rtl/vmtlb_pkg.sv
// Package: shared sizes for the tagged translation cache.
// Assumes: the entry count is at least 2.
package vmtlb_pkg;
    parameter int unsigned TLB_ENTRIES = 16;
    parameter int unsigned TLB_TAG_W   = 8;
    parameter int unsigned TLB_VPN_W   = 36;
    parameter int unsigned TLB_PFN_W   = 28;
endpackage

// File: rtl/vmtlb_cam.sv
// Module: vmtlb_cam
// Compares one key (identifier plus page) against every stored entry
// and returns a one-hot-or-zero vector of matching valid entries.
// Assumes: the owner never stores two valid entries with the same key.
module vmtlb_cam #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned VPN_W   = 36
) (
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    input  logic [TAG_W-1:0]              key_tag,
    input  logic [VPN_W-1:0]              key_vpn,
    output logic [ENTRIES-1:0]            match
);
    // One comparator per entry: valid, same identifier, same page.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_tag[g] == key_tag) && (ent_vpn[g] == key_vpn);
    end
endmodule

// File: rtl/vmtlb_victim.sv
// Module: vmtlb_victim
// Selects the entry a new translation goes to when it is not an overwrite:
// the lowest free entry if one exists, otherwise the rotating pointer.
// Assumes: rr_ptr is always below ENTRIES.
module vmtlb_victim #(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] ent_valid,
    input  logic [IDX_W-1:0]   rr_ptr,
    output logic [IDX_W-1:0]   victim,
    output logic               all_full
);
    logic             free_found;
    logic [IDX_W-1:0] free_idx;

    // Priority scan: the lowest-numbered invalid entry wins.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_valid[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    assign all_full = !free_found;
    assign victim   = free_found ? free_idx : rr_ptr;
endmodule

// File: rtl/vmtlb.sv
// Module: vmtlb
// Fully associative translation cache with a per-entry VM identifier.
// Lookup compares combinationally and the answer is registered one cycle
// later. A miss raises a walk request. Fills overwrite a matching pair,
// else take a free entry, else the round-robin victim. Flushes beat fills.
// Assumes: the walker presents each fill for one cycle.
module vmtlb
    import vmtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = TLB_ENTRIES,
    parameter int unsigned TAG_W   = TLB_TAG_W,
    parameter int unsigned VPN_W   = TLB_VPN_W,
    parameter int unsigned PFN_W   = TLB_PFN_W,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [PFN_W-1:0] rsp_pfn,
    output logic             walk_req,
    output logic [VPN_W-1:0] walk_vpn,
    output logic [TAG_W-1:0] walk_tag,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             flush_tag_valid,
    input  logic [TAG_W-1:0] flush_tag,
    input  logic             flush_all
);
    logic [ENTRIES-1:0]            valid_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tag_q;
    logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_q;
    logic [IDX_W-1:0]              rr_q;

    logic [ENTRIES-1:0] lk_match, fill_match;
    logic [PFN_W-1:0]   lk_pfn;
    logic [IDX_W-1:0]   match_idx, victim_idx, wr_idx;
    logic               all_full, fill_hits, fill_go;

    vmtlb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .VPN_W(VPN_W)) u_lk_cam (
        .ent_valid(valid_q), .ent_tag(tag_q), .ent_vpn(vpn_q),
        .key_tag(lk_tag), .key_vpn(lk_vpn), .match(lk_match)
    );

    vmtlb_cam #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .VPN_W(VPN_W)) u_fill_cam (
        .ent_valid(valid_q), .ent_tag(tag_q), .ent_vpn(vpn_q),
        .key_tag(fill_tag), .key_vpn(fill_vpn), .match(fill_match)
    );

    vmtlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .ent_valid(valid_q), .rr_ptr(rr_q), .victim(victim_idx), .all_full(all_full)
    );

    // Frame mux for the lookup: OR of the frames of matching entries.
    always_comb begin
        lk_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (lk_match[i]) lk_pfn = lk_pfn | pfn_q[i];
        end
    end

    // Encode the entry a fill collides with, if any.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (fill_match[i]) match_idx = IDX_W'(i);
        end
    end

    assign fill_hits = |fill_match;
    assign fill_go   = fill_valid && !flush_all && !flush_tag_valid;
    assign wr_idx    = fill_hits ? match_idx : victim_idx;

    // Valid bits: flushes first, otherwise mark the written entry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_all) begin
            valid_q <= '0;
        end else if (flush_tag_valid) begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (tag_q[i] == flush_tag) valid_q[i] <= 1'b0;
            end
        end else if (fill_valid) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: written on an accepted fill, no reset needed.
    always_ff @(posedge clk) begin
        if (fill_go) begin
            tag_q[wr_idx] <= fill_tag;
            vpn_q[wr_idx] <= fill_vpn;
            pfn_q[wr_idx] <= fill_pfn;
        end
    end

    // Rotating pointer: advances only when a full cache evicts.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_all) begin
            rr_q <= '0;
        end else if (fill_go && !fill_hits && all_full) begin
            rr_q <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
        end
    end

    // Registered answer to this cycle's lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_pfn   <= '0;
            walk_req  <= 1'b0;
            walk_vpn  <= '0;
            walk_tag  <= '0;
        end else begin
            rsp_valid <= lk_valid;
            rsp_hit   <= lk_valid && (|lk_match);
            rsp_pfn   <= lk_valid ? lk_pfn : '0;
            walk_req  <= lk_valid && !(|lk_match);
            walk_vpn  <= lk_vpn;
            walk_tag  <= lk_tag;
        end
    end
endmodule

// File: rtl/vmtlb_checker.sv
// Module: vmtlb_checker
// Temporal checks on the cache's ports and its valid vector.
// Assumes: bound to vmtlb with matching parameters.
module vmtlb_checker #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 8,
    parameter int unsigned VPN_W   = 36
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_valid,
    input logic [VPN_W-1:0]   lk_vpn,
    input logic [TAG_W-1:0]   lk_tag,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic               walk_req,
    input logic [VPN_W-1:0]   walk_vpn,
    input logic [TAG_W-1:0]   walk_tag,
    input logic               fill_valid,
    input logic               flush_tag_valid,
    input logic               flush_all,
    input logic [ENTRIES-1:0] valid_vec
);
    AST_ANSWER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rsp_valid && (rsp_hit != walk_req))); // R3
    AST_NO_SPURIOUS_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !walk_req)); // R3
    AST_WALK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!walk_req || (walk_vpn == $past(lk_vpn) && walk_tag == $past(lk_tag)))); // R4
    AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !flush_all && !flush_tag_valid) |=> (valid_vec != '0)); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_vec == '0)); // R10
    AST_FLUSH_BEATS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_all && fill_valid) |=> (valid_vec == '0)); // R12
endmodule

bind vmtlb vmtlb_checker #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .VPN_W(VPN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_tag(lk_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .walk_req(walk_req),
    .walk_vpn(walk_vpn), .walk_tag(walk_tag), .fill_valid(fill_valid),
    .flush_tag_valid(flush_tag_valid), .flush_all(flush_all), .valid_vec(valid_q)
);

// File: tb/tb_vmtlb.sv
// Directed bench for vmtlb: one task per scenario, each checking itself.
module tb_vmtlb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_vpn = '0;
    logic [7:0]  lk_tag = '0;
    logic        rsp_valid, rsp_hit, walk_req;
    logic [27:0] rsp_pfn;
    logic [35:0] walk_vpn;
    logic [7:0]  walk_tag;
    logic        fill_valid = 1'b0;
    logic [35:0] fill_vpn = '0;
    logic [7:0]  fill_tag = '0;
    logic [27:0] fill_pfn = '0;
    logic        flush_tag_valid = 1'b0;
    logic [7:0]  flush_tag = '0;
    logic        flush_all = 1'b0;

    int n_vec = 0;
    int n_bad = 0;

    always #10ns clk = ~clk;

    vmtlb dut (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_tag(lk_tag),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .walk_req(walk_req),
        .walk_vpn(walk_vpn), .walk_tag(walk_tag), .fill_valid(fill_valid),
        .fill_vpn(fill_vpn), .fill_tag(fill_tag), .fill_pfn(fill_pfn),
        .flush_tag_valid(flush_tag_valid), .flush_tag(flush_tag), .flush_all(flush_all)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Lookup at a falling edge; the answer is sampled at the next falling edge.
    task automatic lookup(input string req, input logic [35:0] v, input logic [7:0] t,
                          input logic exp_hit, input logic [27:0] exp_pfn);
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = v; lk_tag = t;
        @(negedge clk);
        lk_valid = 1'b0;
        check({req, " rsp_valid"}, 64'(rsp_valid), 64'(1));
        check({req, " hit"}, 64'(rsp_hit), 64'(exp_hit));
        check({req, " pfn"}, 64'(rsp_pfn), exp_hit ? 64'(exp_pfn) : 64'(0));
        check({req, " walk_req"}, 64'(walk_req), 64'(!exp_hit));
        if (!exp_hit) begin
            check({req, " walk_vpn"}, 64'(walk_vpn), 64'(v));
            check({req, " walk_tag"}, 64'(walk_tag), 64'(t));
        end
    endtask

    task automatic fill(input logic [35:0] v, input logic [7:0] t, input logic [27:0] p);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = v; fill_tag = t; fill_pfn = p;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_flush_all();
        @(negedge clk); flush_all = 1'b1;
        @(negedge clk); flush_all = 1'b0;
    endtask

    task automatic do_flush_tag(input logic [7:0] t);
        @(negedge clk); flush_tag_valid = 1'b1; flush_tag = t;
        @(negedge clk); flush_tag_valid = 1'b0;
    endtask

    // R1: reset state and a lookup miss on an empty cache.
    task automatic t_reset();
        check("R1 rsp_valid", 64'(rsp_valid), 64'(0));
        check("R1 rsp_hit", 64'(rsp_hit), 64'(0));
        check("R1 walk_req", 64'(walk_req), 64'(0));
        lookup("R1 empty", 36'h123, 8'h01, 1'b0, '0);
        @(negedge clk);
        check("R3 idle rsp_valid", 64'(rsp_valid), 64'(0));
    endtask

    // R2 R5 R11: same page under two identifiers, tag switching.
    task automatic t_tags();
        do_flush_all();
        fill(36'hA_BCDE_0001, 8'h11, 28'h100_0001);
        fill(36'hA_BCDE_0001, 8'h22, 28'h200_0002);
        lookup("R5 tag11", 36'hA_BCDE_0001, 8'h11, 1'b1, 28'h100_0001);
        lookup("R5 tag22", 36'hA_BCDE_0001, 8'h22, 1'b1, 28'h200_0002);
        lookup("R2 other tag", 36'hA_BCDE_0001, 8'h33, 1'b0, '0);
        lookup("R2 other page", 36'hA_BCDE_0002, 8'h11, 1'b0, '0);
        lookup("R11 back to tag11", 36'hA_BCDE_0001, 8'h11, 1'b1, 28'h100_0001);
    endtask

    // R6: refill of an existing pair, then fill to capacity.
    task automatic t_overwrite();
        do_flush_all();
        fill(36'h7, 8'h05, 28'h111);
        fill(36'h7, 8'h05, 28'h222);
        lookup("R6 new frame", 36'h7, 8'h05, 1'b1, 28'h222);
        for (int i = 1; i < 16; i++) fill(36'(100 + i), 8'h05, 28'(i));
        lookup("R6 pair kept", 36'h7, 8'h05, 1'b1, 28'h222);
        for (int i = 1; i < 16; i++) lookup("R6 others", 36'(100 + i), 8'h05, 1'b1, 28'(i));
    endtask

    // R9 R7: flush one identifier, refill freed entries only.
    task automatic t_flush_tag();
        do_flush_all();
        for (int i = 0; i < 8; i++) fill(36'(i), 8'h02, 28'(16'h200 + i));
        for (int i = 0; i < 8; i++) fill(36'(i), 8'h01, 28'(16'h100 + i));
        do_flush_tag(8'h01);
        lookup("R9 flushed", 36'h3, 8'h01, 1'b0, '0);
        lookup("R9 survivor", 36'h3, 8'h02, 1'b1, 28'h203);
        for (int i = 0; i < 8; i++) fill(36'(i), 8'h03, 28'(16'h300 + i));
        for (int i = 0; i < 8; i++) lookup("R7 tag02 kept", 36'(i), 8'h02, 1'b1, 28'(16'h200 + i));
        for (int i = 0; i < 8; i++) lookup("R7 tag03 in", 36'(i), 8'h03, 1'b1, 28'(16'h300 + i));
    endtask

    // R8: rotation once all entries are valid.
    task automatic t_rotate();
        do_flush_all();
        for (int i = 0; i < 16; i++) fill(36'(1000 + i), 8'h09, 28'(500 + i));
        fill(36'd1016, 8'h09, 28'd516);
        lookup("R8 first victim", 36'd1000, 8'h09, 1'b0, '0);
        lookup("R8 second kept", 36'd1001, 8'h09, 1'b1, 28'd501);
        lookup("R8 newcomer", 36'd1016, 8'h09, 1'b1, 28'd516);
        fill(36'd1017, 8'h09, 28'd517);
        lookup("R8 second victim", 36'd1001, 8'h09, 1'b0, '0);
        lookup("R8 third kept", 36'd1002, 8'h09, 1'b1, 28'd502);
    endtask

    // R10 R12: flush everything, and fills colliding with flushes.
    task automatic t_flush_all();
        fill(36'h55, 8'h07, 28'h55);
        do_flush_all();
        lookup("R10 cleared", 36'h55, 8'h07, 1'b0, '0);
        lookup("R10 cleared old", 36'd1002, 8'h09, 1'b0, '0);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 36'h66; fill_tag = 8'h07; fill_pfn = 28'h66;
        flush_all = 1'b1;
        @(negedge clk);
        fill_valid = 1'b0; flush_all = 1'b0;
        lookup("R12 vs flush_all", 36'h66, 8'h07, 1'b0, '0);
        @(negedge clk);
        fill_valid = 1'b1; fill_vpn = 36'h77; fill_tag = 8'h07; fill_pfn = 28'h77;
        flush_tag_valid = 1'b1; flush_tag = 8'h44;
        @(negedge clk);
        fill_valid = 1'b0; flush_tag_valid = 1'b0;
        lookup("R12 vs flush_tag", 36'h77, 8'h07, 1'b0, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_tags();
        t_overwrite();
        t_flush_tag();
        t_rotate();
        t_flush_all();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20ns * 200000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule